// File: doc/BRIEF.md
# Periodic Interval Timer with Buffered Reload

The block counts down a 16-bit counter on every pulse of an 8192 Hz tick enable. When a tick arrives while the counter already holds zero, the counter takes a fresh start value from a separate reload register instead of decrementing. The same tick raises a sticky status flag, and that flag can drive an interrupt line. A reload value of N therefore gives a period of N+1 ticks. A value of 15 gives exactly 512 periods per second.

Software can rewrite the reload register at any moment, and the counter keeps running on its old value until the next wrap. A write-through control bit makes a write to the reload register also load the counter at once. That lets software restart the period from a known value. A run bit gates counting. The tick source is outside the block.

Register map on the 2-bit address bus (data is 16 bits wide):

| Address | Access | Meaning |
|---|---|---|
| 0 | read/write | reload value |
| 1 | read/write | control: bit 0 run, bit 1 interrupt enable, bit 2 write-through; other bits read 0 |
| 2 | read, write-1-to-clear | status: bit 0 wrap flag; other bits read 0 |
| 3 | read only | live counter value |

Top module: `pit_timer`

## Requirements
- R1: After reset the counter and the reload register read 0xFFFF, and control, status and `irq` are all 0.
- R2: When the run bit (control bit 0) is 1 and `tick_en` is high, a nonzero counter decreases by one. Without `tick_en` the counter holds its value.
- R3: A tick while run is 1 and the counter is 0 is a wrap. On a wrap the counter loads the reload register, so a reload value N gives one wrap every N+1 ticks.
- R4: A write to the reload register with write-through (control bit 2) at 0 leaves the counter untouched. If that write falls on a wrap, the counter loads the reload value held before the write.
- R5: With write-through at 1, a write to address 0 loads the written value into the counter on the same clock edge, whether run is 1 or 0.
- R6: While run is 0, ticks do not change the counter.
- R7: A wrap sets status bit 0. Writing 1 to bit 0 of address 2 clears the flag, and writing 0 there has no effect.
- R8: When a clear write and a wrap fall in the same cycle, the flag ends up set.
- R9: When a write-through write falls on a wrap, the counter takes the newly written value rather than the old reload value, and the flag is still set.
- R10: `irq` is high exactly when the status flag is 1 and the interrupt enable (control bit 1) is 1.
- R11: With a reload value of 15 and a tick on every one of 8192 consecutive cycles, exactly 512 wraps occur.
- R12: Writes to address 3 are ignored. Control bits above bit 2 and status bits above bit 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at 8192 Hz that advances the counter |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Three pairs of events can land on the same clock edge. The first pair is a wrap with a flag clear. The second is a wrap with a plain reload-register write. The third is a wrap with a write-through write. The bench brings the counter to zero by counting, then issues the write in the very cycle that carries the wrapping tick. It then judges the result through the status register and the counter read-back: the flag must stay set, the old reload value must be used, and the new value must be used, respectively. A sweep over small reload values compares the counter with arithmetic expectations on every tick.

// File: rtl/pit_pkg.sv
// Shared definitions for the periodic interval timer.
// Assumes a 2-bit register address and a data bus as wide as the counter.
package pit_pkg;

    localparam int ADDR_W = 2;

    // Register addresses on the bus
    typedef enum logic [ADDR_W-1:0] {
        A_RELOAD = 2'd0,
        A_CTRL   = 2'd1,
        A_STATUS = 2'd2,
        A_COUNT  = 2'd3
    } pit_addr_e;

    // Bit positions within the control register
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_IEN_BIT  = 1;
    localparam int CTRL_WTHR_BIT = 2;
    localparam int CTRL_BITS     = 3;

    // Control register contents
    typedef struct packed {
        logic wthru;
        logic ien;
        logic run;
    } pit_ctrl_t;

    // Bit position of the wrap flag within the status register
    localparam int STAT_FLAG_BIT = 0;

endpackage

// File: rtl/pit_regs.sv
// Register file of the interval timer: reload value, control bits,
// write decode and the read multiplexer.
// Assumes a single-cycle write strobe.
// Reads are combinational from bus_addr.
module pit_regs
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [CNT_W-1:0]     bus_wdata,
    input  logic [CNT_W-1:0]     cnt_value,
    input  logic                 flag,
    output logic [CNT_W-1:0]     bus_rdata,
    output logic [CNT_W-1:0]     reload_q,
    output pit_ctrl_t            ctrl_q,
    output logic                 wt_load,
    output logic [CNT_W-1:0]     wt_value,
    output logic                 flag_clr
);

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;
    localparam int PAD_CTRL = CNT_W - CTRL_BITS;
    localparam int PAD_STAT = CNT_W - 1;

    logic wr_reload;
    logic wr_ctrl;
    logic wr_status;

    // Decode the write strobe per address
    always_comb begin
        wr_reload = bus_we && (bus_addr == A_RELOAD);
        wr_ctrl   = bus_we && (bus_addr == A_CTRL);
        wr_status = bus_we && (bus_addr == A_STATUS);
    end

    // Hold the reload value; software may rewrite it at any time
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= RELOAD_RST;
        else if (wr_reload)
            reload_q <= bus_wdata;
    end

    // Hold the control bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl) begin
            ctrl_q.run   <= bus_wdata[CTRL_RUN_BIT];
            ctrl_q.ien   <= bus_wdata[CTRL_IEN_BIT];
            ctrl_q.wthru <= bus_wdata[CTRL_WTHR_BIT];
        end
    end

    // Requests sent to the counter and the flag
    always_comb begin
        wt_load  = wr_reload && ctrl_q.wthru;
        wt_value = bus_wdata;
        flag_clr = wr_status && bus_wdata[STAT_FLAG_BIT];
    end

    // Read multiplexer; unused bits read as zero
    always_comb begin
        unique case (pit_addr_e'(bus_addr))
            A_RELOAD: bus_rdata = reload_q;
            A_CTRL:   bus_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
            A_STATUS: bus_rdata = {{PAD_STAT{1'b0}}, flag};
            A_COUNT:  bus_rdata = cnt_value;
            default:  bus_rdata = '0;
        endcase
    end

    // R4: a write to the reload register lands in it on the next edge
    assert_reload_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> (reload_q == $past(bus_wdata)));

    // R12: control bits change only through a control write
    assert_ctrl_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/pit_downcounter.sv
// Active down-counter of the interval timer.
// On an enabled tick it decrements, and at zero it reloads.
// A write-through request overrides both and loads its value directly.
// Assumes tick_en is a one-cycle pulse.
module pit_downcounter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic [CNT_W-1:0] reload_q,
    input  logic             wt_load,
    input  logic [CNT_W-1:0] wt_value,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_RST = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             step;
    logic             at_zero;
    logic [CNT_W-1:0] cnt_d;

    // Work out whether this cycle advances the count and whether it wraps
    always_comb begin
        step    = tick_en && run;
        at_zero = (cnt_q == '0);
        wrap    = step && at_zero;
    end

    // Next-state choice: write-through first, then wrap reload, then decrement
    always_comb begin
        if (wt_load)
            cnt_d = wt_value;
        else if (wrap)
            cnt_d = reload_q;
        else if (step)
            cnt_d = cnt_q - CNT_ONE;
        else
            cnt_d = cnt_q;
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_RST;
        else
            cnt_q <= cnt_d;
    end

    // R2: an enabled tick on a nonzero count decrements by one
    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run && (cnt_q != '0) && !wt_load) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    // R3: a wrap loads the reload register content
    assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run && (cnt_q == '0) && !wt_load) |=> (cnt_q == $past(reload_q)));

    // R5 and R9: write-through always wins
    assert_write_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wt_load |=> (cnt_q == $past(wt_value)));

    // R6: without an enabled tick or a load the count holds
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_en && run) && !wt_load) |=> $stable(cnt_q));

endmodule

// File: rtl/pit_flag.sv
// Sticky wrap flag with write-one-to-clear.
// A wrap in the same cycle as a clear leaves the flag set.
// Assumes wrap and clr are single-cycle requests.
module pit_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic clr,
    output logic flag_q
);

    // Set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (wrap)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    // R7: a wrap always leaves the flag set
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);

    // R7: a clear without a wrap drops the flag
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wrap) |=> !flag_q);

    // R8: the flag only rises through a wrap
    assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(wrap));

endmodule

// File: rtl/pit_timer.sv
// Top level of the periodic interval timer.
// It joins the register file, the down-counter and the wrap flag, and it gates the interrupt.
// Assumes tick_en is a one-cycle pulse at 8192 Hz generated elsewhere.
module pit_timer
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    pit_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wt_value;
    logic             wt_load;
    logic             flag_clr;
    logic             flag_q;
    logic             wrap;

    // Registers and bus decode
    pit_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_value (cnt_q),
        .flag      (flag_q),
        .bus_rdata (bus_rdata),
        .reload_q  (reload_q),
        .ctrl_q    (ctrl_q),
        .wt_load   (wt_load),
        .wt_value  (wt_value),
        .flag_clr  (flag_clr)
    );

    // Active counter
    pit_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run      (ctrl_q.run),
        .reload_q (reload_q),
        .wt_load  (wt_load),
        .wt_value (wt_value),
        .cnt_q    (cnt_q),
        .wrap     (wrap)
    );

    // Wrap flag
    pit_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .clr    (flag_clr),
        .flag_q (flag_q)
    );

    // Interrupt request: flag gated by the enable bit
    always_comb irq = flag_q && ctrl_q.ien;

    // R10: a raised interrupt is always preceded by a wrap or an enable write
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(wrap) || $past(bus_we)));

endmodule

// File: tb/pit_timer_bench.sv
// Self-checking bench for pit_timer. Inputs are driven 1 ns after a rising edge and sampled at the same point.
module pit_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         bus_we = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pit_timer #(.CNT_W(W)) u_pit_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // One clock cycle with optional write and tick
    task automatic cyc(input bit we, input logic [1:0] a, input logic [W-1:0] d, input bit t);
        bus_we = we; bus_addr = a; bus_wdata = d; tick_en = t;
        @(posedge clk); #1;
        bus_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [W-1:0] exp);
        logic [W-1:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        int wraps;
        bit pend;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_reg("R1 count", 2'd3, 16'hFFFF);
        chk_reg("R1 reload", 2'd0, 16'hFFFF);
        chk_reg("R1 ctrl", 2'd1, 16'h0000);
        chk_reg("R1 status", 2'd2, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R2/R3: sweep reload values, check count every tick
        for (int n = 0; n < 10; n++) begin
            cyc(1, 2'd1, 16'h0004, 0);
            cyc(1, 2'd0, W'(n), 0);
            cyc(1, 2'd2, 16'h0001, 0);
            cyc(1, 2'd1, 16'h0005, 0);
            cyc(0, 2'd0, 0, 0);
            chk_reg("R2 hold without tick", 2'd3, W'(n));
            for (int k = 1; k <= n + 1; k++) begin
                cyc(0, 2'd0, 0, 1);
                chk_reg("R2/R3 count", 2'd3, (k <= n) ? W'(n - k) : W'(n));
                chk_reg("R3 wrap flag", 2'd2, (k == n + 1) ? 16'd1 : 16'd0);
            end
        end

        // R4: buffered reload
        cyc(1, 2'd1, 16'h0004, 0);
        cyc(1, 2'd0, 16'd5, 0);
        cyc(1, 2'd1, 16'h0001, 0);
        cyc(1, 2'd2, 16'h0001, 0);
        cyc(0, 2'd0, 0, 1);
        cyc(0, 2'd0, 0, 1);
        chk_reg("R2 count after two ticks", 2'd3, 16'd3);
        cyc(1, 2'd0, 16'd9, 1);
        chk_reg("R4 plain write leaves count", 2'd3, 16'd2);
        cyc(0, 2'd0, 0, 1);
        cyc(0, 2'd0, 0, 1);
        chk_reg("R4 count at zero", 2'd3, 16'd0);
        cyc(0, 2'd0, 0, 1);
        chk_reg("R4 new reload used at wrap", 2'd3, 16'd9);
        for (int k = 0; k < 9; k++) cyc(0, 2'd0, 0, 1);
        chk_reg("R4 count at zero again", 2'd3, 16'd0);
        cyc(1, 2'd0, 16'd4, 1);
        chk_reg("R4 write on wrap uses old reload", 2'd3, 16'd9);
        chk_reg("R4 reload register updated", 2'd0, 16'd4);

        // R6/R5: stopped counter, write-through
        cyc(1, 2'd1, 16'h0004, 0);
        for (int k = 0; k < 3; k++) cyc(0, 2'd0, 0, 1);
        chk_reg("R6 stopped count holds", 2'd3, 16'd9);
        cyc(1, 2'd0, 16'h1234, 0);
        chk_reg("R5 write-through while stopped", 2'd3, 16'h1234);

        // R8/R7: clear versus wrap
        cyc(1, 2'd0, 16'd0, 0);
        cyc(1, 2'd1, 16'h0005, 0);
        cyc(1, 2'd2, 16'h0001, 0);
        cyc(0, 2'd0, 0, 1);
        chk_reg("R7 wrap sets flag", 2'd2, 16'd1);
        cyc(1, 2'd2, 16'h0001, 1);
        chk_reg("R8 clear on wrap keeps flag", 2'd2, 16'd1);
        cyc(1, 2'd2, 16'h0000, 0);
        chk_reg("R7 write 0 ignored", 2'd2, 16'd1);
        cyc(1, 2'd2, 16'h0001, 0);
        chk_reg("R7 write 1 clears", 2'd2, 16'd0);

        // R9: write-through on a wrap
        cyc(1, 2'd0, 16'd3, 0);
        for (int k = 0; k < 3; k++) cyc(0, 2'd0, 0, 1);
        chk_reg("R9 count at zero", 2'd3, 16'd0);
        cyc(1, 2'd0, 16'd7, 1);
        chk_reg("R9 written value wins", 2'd3, 16'd7);
        chk_reg("R9 flag still set", 2'd2, 16'd1);
        cyc(0, 2'd0, 0, 1);
        chk_reg("R9 counts on from new value", 2'd3, 16'd6);

        // R10: interrupt gating
        cyc(1, 2'd0, 16'd0, 0);
        cyc(1, 2'd1, 16'h0007, 0);
        cyc(0, 2'd0, 0, 1);
        chk("R10 irq with flag and enable", {15'd0, irq}, 16'd1);
        cyc(1, 2'd1, 16'h0004, 0);
        chk("R10 irq masked", {15'd0, irq}, 16'd0);
        cyc(1, 2'd1, 16'h0002, 0);
        chk("R10 irq re-enabled", {15'd0, irq}, 16'd1);
        cyc(1, 2'd2, 16'h0001, 0);
        chk("R10 irq after clear", {15'd0, irq}, 16'd0);

        // R12: read-only count and reserved bits
        cyc(1, 2'd1, 16'hFFFF, 0);
        chk_reg("R12 ctrl reserved bits", 2'd1, 16'h0007);
        cyc(1, 2'd1, 16'h0000, 0);
        cyc(1, 2'd3, 16'hABCD, 0);
        chk_reg("R12 count write ignored", 2'd3, 16'd0);
        cyc(1, 2'd2, 16'hFFFE, 0);
        chk_reg("R12 status reserved bits", 2'd2, 16'h0000);

        // R11: 512 wraps in 8192 ticks with reload 15
        cyc(1, 2'd1, 16'h0004, 0);
        cyc(1, 2'd0, 16'd15, 0);
        cyc(1, 2'd2, 16'h0001, 0);
        cyc(1, 2'd1, 16'h0001, 0);
        wraps = 0; pend = 1'b0;
        for (int k = 0; k < 8192; k++) begin
            cyc(pend, 2'd2, 16'h0001, 1);
            rd(2'd2, v);
            pend = v[0];
            if (v[0]) wraps++;
        end
        chk("R11 wraps per second", W'(wraps), 16'd512);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule